// File: doc/BRIEF.md
# Multilevel Interleaved SEC Memory Scrubber

This block scrubs a small on-chip SRAM whose contents are fixed. It visits the memory one row (a frame) at a time, always in the same order. A physical row holds `ILV_D` codewords that are bit-interleaved. Each codeword's own check bits and an independent parity bit are kept in a separate check row. Those check rows are protected in turn by a second code level. The check bits for that second level are not stored in memory at all. They come from a constant seed input, which the scrubber can never alter.

The block first tests the cheap parity bit of each frame. When parity and syndrome both agree, the frame is clean and is left alone. When a single-error syndrome points at a data bit, the scrubber writes the repaired row back, reads it again, and pulses `corrected` once the re-read is clean. Frames that cannot be repaired raise `uncorrectable` and memory is not touched. Every pass repairs all check rows from the seed before any data row, so a data row is always repaired against check bits that are already correct.

Top module: `mlsec_scrubber`

## Requirements
- R1: For a codeword of `dw` data bits the check width is the smallest `r` with 2^r >= dw + r + 1. Data bit j is given the j-th integer, counting up from 3, that is not a power of two. Check bit i is the XOR of the data bits whose number has bit i set. The parity bit is the XOR of all data bits. Check bits are not covered by their own code.
- R2: Rows 0..N-1 hold data. Bit j of lane k is at physical position j*D+k. Row N+f is the check row of data row f: check bit j of lane k is at j*D+k, and the lane's parity bit is at j=R1. The seed holds the level-2 check and parity bits for the R1+1 low bits of each lane of check row f. These are at bit f*D*(R2+1)+j*D+k, with parity at j=R2.
- R3: A single flipped bit in a data row is repaired within one scrub pass. Every write the block issues carries the correct row content.
- R4: Up to D adjacent flipped bits within one row are repaired in a single write, and that frame produces exactly one `corrected` pulse.
- R5: Flips in a check row are repaired from the seed. All check rows are scrubbed before any data row, so a check-row flip and a data flip in the same frame are both repaired in the same pass.
- R6: If parity matches but the syndrome is nonzero, `uncorrectable` pulses and no write is issued.
- R7: If parity fails but the syndrome does not name a data bit, `uncorrectable` pulses and no write is issued.
- R8: A repair write is followed in the next cycle by a read of the same address. `corrected` is a one-cycle pulse, three cycles after that write. `corrected` and `uncorrectable` are never high together.
- R9: `busy` stays high for 3 cycles per check row and 5 cycles per data row, plus 3 cycles for each frame that is written. The memory port is idle whenever `busy` is low. A clean frame causes no write.
- R10: `scrub_en` is sampled while idle and at the end of each pass. If it is held high, passes run back to back with `busy` staying high. If it is low at the end of a pass, the block returns to idle.
- R11: While in reset, `busy`, `corrected`, `uncorrectable`, `mem_rd_en` and `mem_wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scrub_en | input | 1 | Run request, sampled when idle and at the end of a pass |
| seed_i | input | NUM_FRAMES*ILV_D*(R2+1) | Constant top-level check and parity bits |
| mem_rd_en | output | 1 | Read strobe; data is returned one cycle later |
| mem_wr_en | output | 1 | Write strobe |
| mem_addr | output | AW | Row address |
| mem_wdata | output | ILV_D*DATA_W | Repaired row |
| mem_rdata | input | ILV_D*DATA_W | Row read data, valid the cycle after `mem_rd_en` |
| busy | output | 1 | High while a pass is running |
| corrected | output | 1 | One-cycle pulse after a confirmed repair |
| uncorrectable | output | 1 | One-cycle pulse for a frame that cannot be repaired |

## Verification
Results arrive late because the memory read takes one cycle and each frame runs through fixed states. A repair write comes two cycles after its read strobe. Its verify read comes the cycle after the write, and `corrected` appears three cycles after the write. The length of a pass is exactly 32 cycles for the default four frames, plus 3 for each repaired frame. The bench loads the memory and drives `scrub_en` on falling edges. It keeps a behavioural model of the memory and of the golden content. On every falling edge it compares each write against the golden row and checks that a write is followed by its verify read. It counts `busy` cycles and status pulses and compares them with the values worked out above. The whole memory is compared only after `busy` has dropped and two more edges have passed, so that the last pulse has already been counted.

// File: rtl/mlsec_pkg.sv
// Package: shared helpers for the multilevel scrubber.
// Provides the check-width rule and the data-bit numbering of the
// single-error-correcting code. Both are used to size and wire the lanes.
package mlsec_pkg;

    // Smallest r with 2^r >= dw + r + 1.
    function automatic int chk_bits(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    // Number of data bit j: the j-th non-power-of-two, counting from 3.
    function automatic int code_pos(input int j);
        int p;
        int n;
        p = 2;
        n = -1;
        while (n < j) begin
            p++;
            if ((p & (p - 1)) != 0) n++;
        end
        return p;
    endfunction

    typedef enum logic [3:0] {
        ST_IDLE, ST_REF_RD, ST_REF_CAP, ST_RD, ST_EVAL,
        ST_WR, ST_VRD, ST_VCHK, ST_NEXT
    } scrub_state_e;

endpackage

// File: rtl/mlsec_sec_lane.sv
// Module: one codeword decoder.
// Recomputes the parity and the syndrome of one codeword from its data bits
// and its stored check and parity bits. Produces a flip mask only when
// parity fails and the syndrome names a data bit.
// Assumes RW matches chk_bits(DW). The check bits are not self-covered.
module mlsec_sec_lane #(
    parameter int DW = 8,
    parameter int RW = mlsec_pkg::chk_bits(DW)
) (
    input  logic [DW-1:0] data_i,
    input  logic [RW-1:0] chk_i,
    input  logic          par_i,
    output logic [DW-1:0] flip_o,
    output logic          clean_o,
    output logic          bad_o
);
    logic [RW-1:0] contrib [DW];
    logic [DW-1:0] hit;
    logic [RW-1:0] syn;
    logic          par_err;

    for (genvar j = 0; j < DW; j++) begin : g_bit
        localparam int P = mlsec_pkg::code_pos(j);
        assign contrib[j] = data_i[j] ? RW'(P) : '0;
        assign hit[j]     = (syn == RW'(P));
    end

    // Fold the per-bit contributions onto the stored check bits.
    always_comb begin
        syn = chk_i;
        for (int j = 0; j < DW; j++) syn = syn ^ contrib[j];
    end

    assign par_err = (^data_i) ^ par_i;
    assign flip_o  = par_err ? hit : '0;
    assign clean_o = !par_err && (syn == '0);
    assign bad_o   = par_err ? (hit == '0) : (syn != '0);
endmodule

// File: rtl/mlsec_level.sv
// Module: one code level across all interleaved lanes of a row.
// Lane k takes physical bits j*LANES+k as its data, and reference bits
// i*LANES+k as its check bits, with the parity bit at i=RW. Builds the row
// repair mask and combines the lane status flags.
// Assumes LANES*DW <= W.
module mlsec_level #(
    parameter int  LANES = 4,
    parameter int  DW    = 8,
    parameter int  W     = 32,
    localparam int RW    = mlsec_pkg::chk_bits(DW),
    localparam int REF_W = LANES * (RW + 1)
) (
    input  logic [W-1:0]     word_i,
    input  logic [REF_W-1:0] ref_i,
    output logic [W-1:0]     fix_o,
    output logic             clean_o,
    output logic             bad_o
);
    logic [LANES-1:0] lane_clean;
    logic [LANES-1:0] lane_bad;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [DW-1:0] d;
        logic [RW-1:0] c;
        logic          p;
        logic [DW-1:0] fl;

        for (genvar j = 0; j < DW; j++) begin : g_d
            assign d[j]               = word_i[j*LANES + k];
            assign fix_o[j*LANES + k] = fl[j];
        end
        for (genvar i = 0; i < RW; i++) begin : g_c
            assign c[i] = ref_i[i*LANES + k];
        end
        assign p = ref_i[RW*LANES + k];

        mlsec_sec_lane #(.DW(DW), .RW(RW)) u_lane (
            .data_i (d),
            .chk_i  (c),
            .par_i  (p),
            .flip_o (fl),
            .clean_o(lane_clean[k]),
            .bad_o  (lane_bad[k])
        );
    end

    if (LANES*DW < W) begin : g_pad
        assign fix_o[W-1:LANES*DW] = '0;
    end

    assign clean_o = &lane_clean;
    assign bad_o   = |lane_bad;
endmodule

// File: rtl/mlsec_ctrl.sv
// Module: scrub sequencer.
// Runs a pass over every check row (level 2) and then over every data row
// (level 1). A data row is preceded by a fetch of its check row. A frame
// goes read, evaluate, then optionally write, verify read and verify check.
// Assumes a memory that returns read data one cycle after the strobe.
module mlsec_ctrl #(
    parameter int  NUM_FRAMES = 4,
    localparam int AW = $clog2(2 * NUM_FRAMES),
    localparam int FW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scrub_en,
    input  logic          frame_clean,
    input  logic          frame_bad,
    output logic          lvl_top_o,
    output logic [FW-1:0] idx_o,
    output logic          cap_ref_o,
    output logic          cap_wr_o,
    output logic          rd_en_o,
    output logic          wr_en_o,
    output logic [AW-1:0] addr_o,
    output logic          busy_o,
    output logic          corr_o,
    output logic          unc_o
);
    import mlsec_pkg::*;

    localparam logic [FW-1:0] LAST = FW'(NUM_FRAMES - 1);

    scrub_state_e state;
    logic         lvl_top;
    logic [FW-1:0] idx;
    logic [AW-1:0] chk_addr;
    logic [AW-1:0] dat_addr;

    // Sequence states, advance the frame index and register the status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lvl_top <= 1'b1;
            idx     <= '0;
            corr_o  <= 1'b0;
            unc_o   <= 1'b0;
        end else begin
            corr_o <= 1'b0;
            unc_o  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (scrub_en) begin
                        state   <= ST_RD;
                        lvl_top <= 1'b1;
                        idx     <= '0;
                    end
                end
                ST_REF_RD:  state <= ST_REF_CAP;
                ST_REF_CAP: state <= ST_RD;
                ST_RD:      state <= ST_EVAL;
                ST_EVAL: begin
                    if (frame_bad) begin
                        unc_o <= 1'b1;
                        state <= ST_NEXT;
                    end else if (frame_clean) begin
                        state <= ST_NEXT;
                    end else begin
                        state <= ST_WR;
                    end
                end
                ST_WR:  state <= ST_VRD;
                ST_VRD: state <= ST_VCHK;
                ST_VCHK: begin
                    if (frame_clean) corr_o <= 1'b1;
                    else             unc_o  <= 1'b1;
                    state <= ST_NEXT;
                end
                ST_NEXT: begin
                    if (idx == LAST) begin
                        idx <= '0;
                        if (lvl_top) begin
                            lvl_top <= 1'b0;
                            state   <= ST_REF_RD;
                        end else if (scrub_en) begin
                            lvl_top <= 1'b1;
                            state   <= ST_RD;
                        end else begin
                            state   <= ST_IDLE;
                        end
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= lvl_top ? ST_RD : ST_REF_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign chk_addr = AW'(NUM_FRAMES) + AW'(idx);
    assign dat_addr = AW'(idx);

    // Drive the memory port from the current state.
    always_comb begin
        rd_en_o = (state == ST_REF_RD) || (state == ST_RD) || (state == ST_VRD);
        wr_en_o = (state == ST_WR);
        if (state == ST_REF_RD) addr_o = chk_addr;
        else                    addr_o = lvl_top ? chk_addr : dat_addr;
    end

    assign cap_ref_o = (state == ST_REF_CAP);
    assign cap_wr_o  = (state == ST_EVAL);
    assign busy_o    = (state != ST_IDLE);
    assign lvl_top_o = lvl_top;
    assign idx_o     = idx;
endmodule

// File: rtl/mlsec_scrubber.sv
// Module: multilevel interleaved SEC scrubber (top).
// Rows 0..NUM_FRAMES-1 hold data. Row NUM_FRAMES+f holds the interleaved
// level-1 check and parity bits of data row f. The level-2 check and
// parity bits of each check row come from seed_i and are never written.
// Assumes chk_bits(DATA_W)+1 <= DATA_W, so a check row fits in a word.
module mlsec_scrubber #(
    parameter int  NUM_FRAMES = 4,
    parameter int  DATA_W     = 8,
    parameter int  ILV_D      = 4,
    localparam int R1     = mlsec_pkg::chk_bits(DATA_W),
    localparam int DW2    = R1 + 1,
    localparam int R2     = mlsec_pkg::chk_bits(DW2),
    localparam int W      = ILV_D * DATA_W,
    localparam int REF1_W = ILV_D * (R1 + 1),
    localparam int SEED_F = ILV_D * (R2 + 1),
    localparam int SEED_W = NUM_FRAMES * SEED_F,
    localparam int AW     = $clog2(2 * NUM_FRAMES),
    localparam int FW     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scrub_en,
    input  logic [SEED_W-1:0] seed_i,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_addr,
    output logic [W-1:0]      mem_wdata,
    input  logic [W-1:0]      mem_rdata,
    output logic              busy,
    output logic              corrected,
    output logic              uncorrectable
);
    logic              lvl_top;
    logic [FW-1:0]     frame_idx;
    logic              cap_ref;
    logic              cap_wr;
    logic [REF1_W-1:0] ref_q;
    logic [W-1:0]      wr_q;
    logic [SEED_F-1:0] seed_slice;
    logic [W-1:0]      fix1, fix2, fix_sel;
    logic              clean1, clean2, bad1, bad2;
    logic              frame_clean, frame_bad;

    mlsec_ctrl #(.NUM_FRAMES(NUM_FRAMES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scrub_en   (scrub_en),
        .frame_clean(frame_clean),
        .frame_bad  (frame_bad),
        .lvl_top_o  (lvl_top),
        .idx_o      (frame_idx),
        .cap_ref_o  (cap_ref),
        .cap_wr_o   (cap_wr),
        .rd_en_o    (mem_rd_en),
        .wr_en_o    (mem_wr_en),
        .addr_o     (mem_addr),
        .busy_o     (busy),
        .corr_o     (corrected),
        .unc_o      (uncorrectable)
    );

    assign seed_slice = seed_i[int'(frame_idx)*SEED_F +: SEED_F];

    // Level 2: check row lanes against the constant seed.
    mlsec_level #(.LANES(ILV_D), .DW(DW2), .W(W)) u_lvl2 (
        .word_i (mem_rdata),
        .ref_i  (seed_slice),
        .fix_o  (fix2),
        .clean_o(clean2),
        .bad_o  (bad2)
    );

    // Level 1: data row lanes against the captured check row.
    mlsec_level #(.LANES(ILV_D), .DW(DATA_W), .W(W)) u_lvl1 (
        .word_i (mem_rdata),
        .ref_i  (ref_q),
        .fix_o  (fix1),
        .clean_o(clean1),
        .bad_o  (bad1)
    );

    assign fix_sel     = lvl_top ? fix2   : fix1;
    assign frame_clean = lvl_top ? clean2 : clean1;
    assign frame_bad   = lvl_top ? bad2   : bad1;

    // Hold the check row for a data frame and the repaired row for write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
            wr_q  <= '0;
        end else begin
            if (cap_ref) ref_q <= mem_rdata[REF1_W-1:0];
            if (cap_wr)  wr_q  <= mem_rdata ^ fix_sel;
        end
    end

    assign mem_wdata = wr_q;
endmodule

// File: rtl/mlsec_scrubber_chk.sv
// Module: protocol checker for the scrubber, bound to the top.
// Watches the memory port and the status outputs only.
module mlsec_scrubber_chk #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scrub_en,
    input logic          busy,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_addr,
    input logic          corrected,
    input logic          uncorrectable
);
    p_rdwr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));

    p_verify_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (mem_rd_en && mem_addr == $past(mem_addr)));

    p_corr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        corrected |=> !corrected);

    p_corr_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        corrected |-> $past(mem_wr_en, 3));

    p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(corrected && uncorrectable));

    p_start_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(scrub_en) && mem_rd_en));
endmodule

bind mlsec_scrubber mlsec_scrubber_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scrub_en     (scrub_en),
    .busy         (busy),
    .mem_rd_en    (mem_rd_en),
    .mem_wr_en    (mem_wr_en),
    .mem_addr     (mem_addr),
    .corrected    (corrected),
    .uncorrectable(uncorrectable)
);

// File: tb/mlsec_scrubber_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural memory plus golden content, per-clock write checks,
// and end-of-pass comparison of duration, status pulses and memory.
module mlsec_scrubber_tb_top;
    localparam int N = 4, DW = 8, D = 4, R1 = 4, R2 = 4;
    localparam int W = D*DW, SF = D*(R2+1), SW = N*SF, AW = 3, ROWS = 2*N;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, scrub_en;
    logic [SW-1:0] seed;
    logic          mem_rd_en, mem_wr_en, busy, corrected, uncorrectable;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_wdata, mem_rdata, rdata_q;

    logic [W-1:0] mem    [ROWS];
    logic [W-1:0] golden [ROWS];
    logic [W-1:0] flip   [ROWS];
    logic         load_now;

    mlsec_scrubber #(.NUM_FRAMES(N), .DATA_W(DW), .ILV_D(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .seed_i(seed),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
        .corrected(corrected), .uncorrectable(uncorrectable)
    );

    // Memory model: one-cycle read, preload with injected flips.
    always @(posedge clk) begin
        if (load_now) begin
            for (int i = 0; i < ROWS; i++) mem[i] <= golden[i] ^ flip[i];
        end else if (mem_wr_en) begin
            mem[mem_addr] <= mem_wdata;
        end
        if (mem_rd_en) rdata_q <= mem[mem_addr];
    end
    assign mem_rdata = rdata_q;

    // Per-clock monitor.
    int mon_checks = 0, mon_errors = 0, n_corr = 0, n_unc = 0, n_wr = 0;
    logic prev_wr = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (corrected) n_corr++;
            if (uncorrectable) n_unc++;
            if (corrected && uncorrectable) begin
                mon_errors++;
                $display("FAIL R8: both flags high got 1 expected 0");
            end
            if (!busy && (mem_rd_en || mem_wr_en)) begin
                mon_errors++;
                $display("FAIL R9: port active while idle got 1 expected 0");
            end
            if (prev_wr) begin
                mon_checks++;
                if (!(mem_rd_en && mem_addr == prev_addr)) begin
                    mon_errors++;
                    $display("FAIL R8: verify read got addr %0d rd %0d expected addr %0d rd 1",
                             mem_addr, mem_rd_en, prev_addr);
                end
            end
            if (mem_wr_en) begin
                n_wr++;
                mon_checks++;
                if (mem_wdata != golden[mem_addr]) begin
                    mon_errors++;
                    $display("FAIL R3: write row %0d got %h expected %h",
                             mem_addr, mem_wdata, golden[mem_addr]);
                end
            end
            prev_wr   = mem_wr_en;
            prev_addr = mem_addr;
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Code number of data bit j (R1): j-th non-power-of-two from 3.
    function automatic int bpos(input int j);
        int cnt = 0;
        for (int v = 3; v < 256; v++) begin
            if ((v & (v - 1)) != 0) begin
                if (cnt == j) return v;
                cnt++;
            end
        end
        return 0;
    endfunction

    // Returns check bits in [r-1:0] and the parity bit at [r].
    function automatic logic [7:0] enc(input logic [7:0] d, input int dw, input int r);
        logic [7:0] c = '0;
        logic p = 1'b0;
        for (int j = 0; j < dw; j++) begin
            if (d[j]) c = c ^ 8'(bpos(j));
            p = p ^ d[j];
        end
        c[r] = p;
        return c;
    endfunction

    task automatic build_golden();
        logic [W-1:0] row, crow;
        logic [7:0] d, e;
        seed = '0;
        for (int f = 0; f < N; f++) begin
            row = 32'hA5C3_1E70 ^ (32'(f) * 32'h1357_9BDF);
            golden[f] = row;
            crow = '0;
            for (int k = 0; k < D; k++) begin
                d = '0;
                for (int j = 0; j < DW; j++) d[j] = row[j*D + k];
                e = enc(d, DW, R1);
                for (int j = 0; j <= R1; j++) crow[j*D + k] = e[j];
            end
            golden[N + f] = crow;
            for (int k = 0; k < D; k++) begin
                d = '0;
                for (int j = 0; j <= R1; j++) d[j] = crow[j*D + k];
                e = enc(d, R1 + 1, R2);
                for (int j = 0; j <= R2; j++) seed[f*SF + j*D + k] = e[j];
            end
        end
    endtask

    task automatic clear_flips();
        for (int i = 0; i < ROWS; i++) flip[i] = '0;
    endtask

    task automatic run_scrub(input int hold, output int dur);
        int guard = 0;
        dur = 0;
        @(negedge clk) scrub_en = 1'b1;
        repeat (hold) begin
            @(negedge clk);
            if (busy) dur++;
        end
        scrub_en = 1'b0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            if (busy) dur++;
            guard++;
        end
        if (guard >= 5000) chk("watchdog pass end", 0, 1);
    endtask

    task automatic scenario(input string tag, input int hold, input int exp_dur,
                            input int exp_corr, input int exp_unc, input int exp_wr,
                            input bit keep_flips);
        int c0, u0, w0, dur, bad;
        @(negedge clk) load_now = 1'b1;
        @(negedge clk) load_now = 1'b0;
        c0 = n_corr; u0 = n_unc; w0 = n_wr;
        run_scrub(hold, dur);
        repeat (2) @(negedge clk);
        chk({tag, " duration"}, dur, exp_dur);
        chk({tag, " corrected"}, n_corr - c0, exp_corr);
        chk({tag, " uncorrectable"}, n_unc - u0, exp_unc);
        chk({tag, " writes"}, n_wr - w0, exp_wr);
        bad = 0;
        for (int i = 0; i < ROWS; i++)
            if (mem[i] != (keep_flips ? (golden[i] ^ flip[i]) : golden[i])) bad++;
        chk({tag, " memory rows wrong"}, bad, 0);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
    endtask

    initial begin
        #(8 * 150000);
        $display("FAIL watchdog: got timeout expected completion");
        errors++;
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0; scrub_en = 1'b0; load_now = 1'b0;
        build_golden();
        clear_flips();
        repeat (4) @(negedge clk);
        // R11 reset state.
        chk("R11 busy", int'(busy), 0);
        chk("R11 rd/wr", int'(mem_rd_en | mem_wr_en), 0);
        chk("R11 corrected", int'(corrected), 0);
        chk("R11 uncorrectable", int'(uncorrectable), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10 stays idle without scrub_en", int'(busy), 0);

        // Clean content: R1 R2 R9.
        clear_flips();
        scenario("R1 R2 R9 clean", 1, 32, 0, 0, 0, 1'b0);

        // Single data flip: R3.
        clear_flips(); flip[1][13] = 1'b1;
        scenario("R3 single data flip", 1, 35, 1, 0, 1, 1'b0);

        // D adjacent flips in one data row: R4.
        clear_flips(); flip[2][11:8] = 4'hF;
        scenario("R4 adjacent data flips", 1, 35, 1, 0, 1, 1'b0);

        // Single check-row flip: R5.
        clear_flips(); flip[N+0][5] = 1'b1;
        scenario("R5 check row flip", 1, 35, 1, 0, 1, 1'b0);

        // D adjacent flips on the parity bits of a check row: R4 R5.
        clear_flips(); flip[N+3][19:16] = 4'hF;
        scenario("R4 R5 adjacent check flips", 1, 35, 1, 0, 1, 1'b0);

        // Check-row and data flip in the same frame: R5 ordering.
        clear_flips(); flip[N+1][2] = 1'b1; flip[1][6] = 1'b1;
        scenario("R5 same frame both levels", 1, 38, 2, 0, 2, 1'b0);

        // Two flips in lane 0 of a data row: parity passes, syndrome 6 (R6).
        clear_flips(); flip[3][0] = 1'b1; flip[3][4] = 1'b1;
        scenario("R6 double error", 1, 32, 0, 1, 0, 1'b1);

        // Three flips in lane 0: parity fails, syndrome 0 (R7).
        clear_flips(); flip[0][0] = 1'b1; flip[0][4] = 1'b1; flip[0][8] = 1'b1;
        scenario("R7 parity fail no target", 1, 32, 0, 1, 0, 1'b1);

        // Back-to-back passes while scrub_en is held: R10.
        clear_flips();
        scenario("R10 continuous three passes", 70, 96, 0, 0, 0, 1'b0);
        repeat (5) @(negedge clk);
        chk("R10 idle after drop", int'(busy), 0);

        report();
        $finish;
    end
endmodule